// File: doc/BRIEF.md
# Prescaled Reference Compare Timer

A 16-bit up-counter with a small byte-addressed register interface. The system clock can first pass through an optional divide-by-16 stage. It then passes through a programmable prescaler that divides by an 8-bit value plus one. Each prescaler output advances the counter by one. When the counter has reached the programmed reference value, the next advance returns it to zero. At that moment a sticky reference event flag is set. The flag drives a level interrupt when the interrupt enable bit in the mode register is set.

Software programs the reference value and then writes the mode register, which starts the count from zero. Software clears the event flag by writing a 1 to its bit. Software may also read the running count or load a new count at any time. If software clears the enable bit of a running timer, the mode and reference registers both return to zero. A plain capture register can be read and written, but no pin logic updates it. Clock codes 0 and 3 never advance the counter. A timer with the restart bit clear does not advance either.

Top module: `refcmp_timer`

## Requirements
- R1: Register offsets are mode 0x00, reference 0x04, capture 0x08, counter 0x0C and event 0x11. The event register returns the reference flag in bit 1, and its other bits read 0. Any other offset reads 0. After reset every register reads 0 and `irq` is low.
- R2: While mode bit 0 (enable) is 0, the counter keeps its value.
- R3: Clock code 1 is mode bits 2:1 = 01. With bit 3 set, P in mode bits 15:8 and reference R, the first event appears (P+1)*(R+1) clock edges after the edge of the mode write.
- R4: Clock code 2 (bits 2:1 = 10) adds a divide by 16 ahead of the prescaler, so the first event appears 16*(P+1)*(R+1) edges after the mode write.
- R5: When an advance finds the counter equal to the reference, the counter goes to 0. Later events therefore repeat with the same period.
- R6: The advance that wraps the counter sets event bit 1, which stays set until software clears it.
- R7: `irq` is high exactly when mode bit 4 and event bit 1 are both 1.
- R8: A write to the event register clears each bit written as 1 and leaves bits written as 0 unchanged.
- R9: When a wrap and a clear of event bit 1 fall on the same edge, the bit stays set.
- R10: A mode write with bit 0 = 0 while bit 0 was 1 sets both the mode and reference registers to 0.
- R11: A counter write loads the written value. It takes priority over an advance on the same edge.
- R12: A write to the mode or reference register restarts the prescaler and sets the counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
A counter wrap and a register write can land on the same edge. The bench provokes two such collisions: a write-one clear of the event bit on the wrap edge, and a counter load on an edge where the prescaler would advance the count. It places each write at an edge counted from the start write. It then checks that the event bit survives the collision and that the loaded value wins. After the next edge it checks that the clear takes effect and that the count has advanced exactly once. Sweeps over prescale values, reference values and both clock codes time the first event and the second event to the exact cycle.

// File: rtl/tmr_pkg.sv
// Shared constants for the reference compare timer.
// Assumes byte offsets fit in five address bits.
package tmr_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_MODE = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_REF  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_CAP  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_EVT  = 5'h11;

    // Mode register bit positions.
    localparam int MB_EN      = 0;
    localparam int MB_CLK_LO  = 1;
    localparam int MB_RESTART = 3;
    localparam int MB_IRQEN   = 4;
    localparam int MB_PS_LO   = 8;

    // Event register bit position of the reference flag.
    localparam int EB_REF = 1;

    typedef enum logic [1:0] {
        CLK_OFF   = 2'd0,
        CLK_SYS   = 2'd1,
        CLK_SYS16 = 2'd2,
        CLK_EXT   = 2'd3
    } clk_sel_e;
endpackage

// File: rtl/tmr_prescaler.sv
// Clock divider chain: an optional fixed divide stage, then a programmable
// divide by (ps_val + 1). Emits a one-cycle tick per counter advance.
// Assumes ps_val changes only together with restart.
module tmr_prescaler #(
    parameter int PS_W     = 8,
    parameter int SLOW_DIV = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            run,
    input  logic            slow_sel,
    input  logic [PS_W-1:0] ps_val,
    output logic            tick
);
    localparam int DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

    logic            slow_pulse;
    logic            stage_pulse;
    logic [PS_W-1:0] ps_q;

    generate
        if (SLOW_DIV > 1) begin : g_slow
            localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOW_DIV - 1);
            logic [DIV_W-1:0] div_q;

            // Fixed pre-divider, held at zero when idle or restarted.
            always_ff @(posedge clk) begin
                if (!rst_n || restart || !run || !slow_sel)
                    div_q <= '0;
                else if (div_q == DIV_LAST)
                    div_q <= '0;
                else
                    div_q <= div_q + 1'b1;
            end

            assign slow_pulse = (div_q == DIV_LAST);
        end else begin : g_noslow
            assign slow_pulse = 1'b1;
        end
    endgenerate

    assign stage_pulse = run && (slow_sel ? slow_pulse : 1'b1);

    // Programmable divider counting stage pulses up to ps_val.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run)
            ps_q <= '0;
        else if (stage_pulse) begin
            if (ps_q == ps_val)
                ps_q <= '0;
            else
                ps_q <= ps_q + 1'b1;
        end
    end

    assign tick = stage_pulse && (ps_q == ps_val);
endmodule

// File: rtl/tmr_counter.sv
// Up-counter that wraps to zero after matching the reference value.
// A restart has priority, then a software load, then a tick.
// Assumes ref_val is stable between restarts.
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic [CNT_W-1:0] ref_val,
    output logic [CNT_W-1:0] cnt,
    output logic             ref_hit
);
    logic [CNT_W-1:0] cnt_q;

    // A wrap counts only when no write overrides the advance.
    assign ref_hit = tick && !restart && !load && (cnt_q == ref_val);

    // Count register update.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (ref_hit)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/tmr_regs.sv
// Register file and decode: mode, reference, capture and event registers,
// the read multiplexer and the interrupt level.
// Assumes single-cycle writes and side-effect-free reads.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int MODE_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              ref_hit,
    output logic [MODE_W-1:0] mode,
    output logic [CNT_W-1:0]  ref_val,
    output logic              evt,
    output logic              restart,
    output logic              cnt_load,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0]  ref_q;
    logic [CNT_W-1:0]  cap_q;
    logic              evt_q;
    logic              wr_mode, wr_ref, wr_cap, wr_evt;
    logic              disabling;

    assign wr_mode   = wr_en && (addr == OFS_MODE);
    assign wr_ref    = wr_en && (addr == OFS_REF);
    assign wr_cap    = wr_en && (addr == OFS_CAP);
    assign wr_evt    = wr_en && (addr == OFS_EVT);
    assign cnt_load  = wr_en && (addr == OFS_CNT);
    assign restart   = wr_mode || wr_ref;
    assign disabling = wr_mode && mode_q[MB_EN] && !wdata[MB_EN];

    // Mode register; turning the enable off wipes it.
    always_ff @(posedge clk) begin
        if (!rst_n || disabling)
            mode_q <= '0;
        else if (wr_mode)
            mode_q <= wdata[MODE_W-1:0];
    end

    // Reference register; cleared together with mode on disable.
    always_ff @(posedge clk) begin
        if (!rst_n || disabling)
            ref_q <= '0;
        else if (wr_ref)
            ref_q <= wdata[CNT_W-1:0];
    end

    // Capture register: plain storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap_q <= '0;
        else if (wr_cap)
            cap_q <= wdata[CNT_W-1:0];
    end

    // Sticky reference flag: set wins over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            evt_q <= 1'b0;
        else if (ref_hit)
            evt_q <= 1'b1;
        else if (wr_evt && wdata[EB_REF])
            evt_q <= 1'b0;
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_MODE: rdata[MODE_W-1:0] = mode_q;
            OFS_REF:  rdata[CNT_W-1:0]  = ref_q;
            OFS_CAP:  rdata[CNT_W-1:0]  = cap_q;
            OFS_CNT:  rdata[CNT_W-1:0]  = cnt;
            OFS_EVT:  rdata[EB_REF]     = evt_q;
            default:  rdata = '0;
        endcase
    end

    assign irq     = mode_q[MB_IRQEN] && evt_q;
    assign mode    = mode_q;
    assign ref_val = ref_q;
    assign evt     = evt_q;
endmodule

// File: rtl/refcmp_timer.sv
// Top of the reference compare timer: register file, prescaler chain and
// counter. Assumes one register access per cycle.
module refcmp_timer
    import tmr_pkg::*;
#(
    parameter  int CNT_W    = 16,
    parameter  int PS_W     = 8,
    parameter  int SLOW_DIV = 16,
    localparam int MODE_W   = MB_PS_LO + PS_W,
    localparam int DATA_W   = (CNT_W > MODE_W) ? CNT_W : MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0]  ref_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              evt_q;
    logic              restart, cnt_load, tick, ref_hit;
    logic              run, slow_sel;
    clk_sel_e          clk_sel;

    assign clk_sel  = clk_sel_e'(mode_q[MB_CLK_LO +: 2]);
    assign slow_sel = (clk_sel == CLK_SYS16);
    assign run      = mode_q[MB_EN] && mode_q[MB_RESTART]
                      && ((clk_sel == CLK_SYS) || (clk_sel == CLK_SYS16));

    tmr_regs #(.CNT_W(CNT_W), .MODE_W(MODE_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .cnt      (cnt_q),
        .ref_hit  (ref_hit),
        .mode     (mode_q),
        .ref_val  (ref_q),
        .evt      (evt_q),
        .restart  (restart),
        .cnt_load (cnt_load),
        .rdata    (rdata),
        .irq      (irq)
    );

    tmr_prescaler #(.PS_W(PS_W), .SLOW_DIV(SLOW_DIV)) u_ps (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .run      (run),
        .slow_sel (slow_sel),
        .ps_val   (mode_q[MB_PS_LO +: PS_W]),
        .tick     (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .load     (cnt_load),
        .load_val (wdata[CNT_W-1:0]),
        .tick     (tick),
        .ref_val  (ref_q),
        .cnt      (cnt_q),
        .ref_hit  (ref_hit)
    );
endmodule

// File: rtl/refcmp_timer_chk.sv
// Checker for the reference compare timer, attached by bind.
// Assumes the top-level internal names mode_q, ref_q, cnt_q, evt_q, tick, ref_hit.
module refcmp_timer_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int MODE_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              irq,
    input logic [MODE_W-1:0] mode_q,
    input logic [CNT_W-1:0]  ref_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              evt_q,
    input logic              tick,
    input logic              ref_hit
);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q[MB_EN] && !wr_en) |=> $stable(cnt_q));

    p_notick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q[MB_EN] |-> !tick);

    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_hit |=> (cnt_q == '0));

    p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ref_hit |=> evt_q);

    p_irq_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q[MB_IRQEN] |-> !irq);

    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_EVT && wdata[EB_REF] && !ref_hit) |=> !evt_q);

    p_disable_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_MODE && mode_q[MB_EN] && !wdata[MB_EN])
        |=> (mode_q == '0 && ref_q == '0));

    p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CNT) |=> (cnt_q == $past(wdata[CNT_W-1:0])));

    p_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == OFS_MODE || addr == OFS_REF)) |=> (cnt_q == '0));
endmodule

bind refcmp_timer refcmp_timer_chk #(
    .CNT_W(CNT_W), .MODE_W(MODE_W), .DATA_W(DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .irq     (irq),
    .mode_q  (mode_q),
    .ref_q   (ref_q),
    .cnt_q   (cnt_q),
    .evt_q   (evt_q),
    .tick    (tick),
    .ref_hit (ref_hit)
);

// File: tb/refcmp_timer_bench.sv
`timescale 1ns/1ps
module refcmp_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    localparam logic [4:0] A_MODE = 5'h00, A_REF = 5'h04, A_CAP = 5'h08,
                           A_CNT = 5'h0C, A_EVT = 5'h11;

    refcmp_timer u_refcmp_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Write lands on the next rising edge; returns just after it.
    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output int v);
        addr = a;
        #1 v = int'(rdata);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #1_500_000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int v;
        int n;
        int exp_n;
        int refs[4] = '{0, 1, 2, 5};
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(A_MODE, v); chk("R1 mode reset", v, 0);
        rd(A_REF, v);  chk("R1 ref reset", v, 0);
        rd(A_CAP, v);  chk("R1 cap reset", v, 0);
        rd(A_CNT, v);  chk("R1 cnt reset", v, 0);
        rd(A_EVT, v);  chk("R1 evt reset", v, 0);
        chk("R1 irq reset", int'(irq), 0);

        // R1 register map readback
        wr(A_REF, 16'h1234); rd(A_REF, v); chk("R1 ref rw", v, 16'h1234);
        wr(A_CAP, 16'hBEEF); rd(A_CAP, v); chk("R1 cap rw", v, 16'hBEEF);
        rd(5'h10, v); chk("R1 unmapped", v, 0);

        // R2 disabled counter holds; no wipe without a 1->0 transition
        wr(A_MODE, 16'h000A);
        wr(A_CNT, 16'h0005);
        repeat (20) @(posedge clk);
        #1 rd(A_CNT, v); chk("R2 hold", v, 5);
        rd(A_MODE, v); chk("R2 mode kept", v, 16'h000A);

        // R10 disable wipes mode and reference
        wr(A_MODE, 16'h001B);
        wr(A_REF, 16'h0007);
        wr(A_MODE, 16'h001A);
        rd(A_MODE, v); chk("R10 mode wiped", v, 0);
        rd(A_REF, v);  chk("R10 ref wiped", v, 0);

        // R11 load wins over advance, then counts each edge (P=0, code 1)
        wr(A_REF, 16'h0010);
        wr(A_MODE, 16'h000B);
        wr(A_CNT, 16'h0003);
        repeat (4) @(posedge clk);
        #1 rd(A_CNT, v); chk("R11 load then count", v, 7);
        // R12 reference write restarts the count
        wr(A_REF, 16'h0010);
        rd(A_CNT, v); chk("R12 ref restart", v, 0);

        // R3 R4 R5 sweep of clock code, prescale and reference
        for (int code = 1; code <= 2; code++) begin
            for (int p = 0; p < 4; p++) begin
                for (int ri = 0; ri < 4; ri++) begin
                    exp_n = ((code == 2) ? 16 : 1) * (p + 1) * (refs[ri] + 1);
                    wr(A_MODE, 16'h0000);
                    wr(A_EVT, 16'h0002);
                    wr(A_REF, 16'(refs[ri]));
                    wr(A_MODE, 16'(p << 8) | 16'h0019 | 16'(code << 1));
                    n = 0;
                    while (!irq && n < 5000) begin
                        @(posedge clk); #1 n++;
                    end
                    chk((code == 2) ? "R4 first event" : "R3 first event", n, exp_n);
                    wr(A_EVT, 16'h0002);
                    n++;
                    while (!irq && n < 10000) begin
                        @(posedge clk); #1 n++;
                    end
                    chk("R5 second event period", n, 2 * exp_n);
                end
            end
        end

        // R9 clear collides with wrap (period 4: events at edges 4, 8, ...)
        wr(A_MODE, 16'h0000);
        wr(A_EVT, 16'h0002);
        wr(A_REF, 16'h0003);
        wr(A_MODE, 16'h001B);
        repeat (7) @(posedge clk);
        wr(A_EVT, 16'h0002);
        rd(A_EVT, v); chk("R9 set wins", v, 2);
        chk("R7 irq on event", int'(irq), 1);
        wr(A_EVT, 16'h0002);
        rd(A_EVT, v); chk("R8 clear next edge", v, 0);
        rd(A_CNT, v); chk("R5 count after wrap", v, 1);

        // R6 R8 R7 flag persistence, zero bits ignored, interrupt gating
        n = 0;
        while (!irq && n < 100) begin
            @(posedge clk); #1 n++;
        end
        wr(A_MODE, 16'hFF1D);
        rd(A_EVT, v); chk("R6 flag sticky", v, 2);
        wr(A_EVT, 16'h0001);
        rd(A_EVT, v); chk("R8 bit0 write no effect", v, 2);
        wr(A_EVT, 16'h00FD);
        rd(A_EVT, v); chk("R8 zero bit kept", v, 2);
        wr(A_MODE, 16'hFF0D);
        chk("R7 irq masked", int'(irq), 0);
        rd(A_EVT, v); chk("R7 flag kept while masked", v, 2);
        wr(A_MODE, 16'hFF1D);
        chk("R7 irq unmasked", int'(irq), 1);
        wr(A_EVT, 16'h0002);
        chk("R8 irq cleared", int'(irq), 0);

        finish_run();
    end
endmodule